// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block decides whether a received frame should be kept, judging only by its 48-bit destination address. The receive path presents the address with a one-cycle strobe. Some cycles later the block raises a one-cycle done pulse, and an accept flag beside it carries the verdict. Nothing else about the frame passes through the block.

A unicast address passes if it equals the station address or one of the enabled exact-match entries. A multicast address passes if it equals an enabled exact-match entry or if it falls in a set bucket of a 256-bucket hash table. The bucket comes from a CRC-32 computed over the address. Two promiscuous switches, one for unicast and one for multicast, open each class fully. A broadcast reject switch overrides everything for the all-ones address. The CRC is computed one octet per clock, so a decision takes a fixed number of cycles. Hash buckets are imprecise: every address that maps to a set bucket is accepted.

Top module: `eth_rx_addr_filter`

## Requirements
- R1: After reset, done and accept are low and every hash bucket is clear.
- R2: A strobe sampled while the block is idle produces a single-cycle done pulse exactly 7 clock edges later. A strobe seen while a decision is in progress is ignored and produces no extra done pulse.
- R3: The group (multicast) flag is bit 40 of the address, which is the least significant bit of the first octet (bits 47:40). Broadcast is the all-ones address.
- R4: With unicast promiscuous mode off, a unicast address is accepted only if it equals the station address or an enabled exact-match entry.
- R5: Exact-match entry i is the concatenation {exact_hi[32i+31:32i], exact_lo[16i+15:16i]}, with the first four octets in the high part. An entry takes part only while exact_en[i] is 1, and it applies to both unicast and multicast addresses.
- R6: The bucket index is bits 31:24 of the CRC-32 of the six address octets. The octets are taken first (bits 47:40) to last, each least significant bit first. The CRC uses the reflected polynomial 0xEDB88320, starts from all ones and is complemented at the end. Index bits 7:5 pick the hash register and bits 4:0 pick the bit within it. A non-broadcast multicast address is accepted when its bucket is set. Unicast addresses never use the hash table.
- R7: When hash_wr_en is high at a clock edge, hash_wr_data is written into the hash register selected by hash_wr_sel.
- R8: When hash_clear is high at a clock edge, every bucket is cleared, and this takes priority over a write in the same cycle. The station address and the exact-match entries are not affected.
- R9: A broadcast address is accepted unless bc_reject is set. When bc_reject is set, a broadcast address is rejected even if promiscuous modes, exact-match entries or the hash table would accept it.
- R10: uc_promisc accepts every unicast address. mc_promisc accepts every non-broadcast multicast address.
- R11: accept is low in every cycle in which done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_valid | input | 1 | Destination address strobe |
| dst_addr | input | 48 | Destination address, first octet in bits 47:40 |
| station_addr | input | 48 | Primary station address |
| exact_hi | input | 32*NUM_EXACT | First four octets of each exact-match entry |
| exact_lo | input | 16*NUM_EXACT | Last two octets of each exact-match entry |
| exact_en | input | NUM_EXACT | Per-entry enable |
| hash_wr_en | input | 1 | Hash register write strobe |
| hash_wr_sel | input | log2(HASH_REGS) | Hash register select |
| hash_wr_data | input | REG_W | Hash register write data |
| hash_clear | input | 1 | Clear all buckets |
| bc_reject | input | 1 | Reject broadcast addresses |
| uc_promisc | input | 1 | Accept all unicast addresses |
| mc_promisc | input | 1 | Accept all multicast addresses |
| done | output | 1 | Decision strobe |
| accept | output | 1 | Decision, valid with done |

## Verification
The bench builds the block with NUM_EXACT = 3 and the default 8 × 32 hash table. Three entries are enough to show an enabled unicast entry, an enabled multicast entry and a disabled entry, and the bench can still model every entry directly. The full 256-bucket table stays in place. Each of 400 multicast addresses is run first against a programmed bucket pattern and then against its inverse, so every address is seen both hitting and missing its own bucket. A sweep of all 48 single-bit flips of the station address exercises the unicast compare and the group-bit decode.

// File: rtl/eth_rx_addr_filter.sv
module eth_rx_addr_filter #(
  parameter int NUM_EXACT = 15,
  parameter int HASH_REGS = 8,
  parameter int REG_W     = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         addr_valid,
  input  logic [47:0]                  dst_addr,
  input  logic [47:0]                  station_addr,
  input  logic [32*NUM_EXACT-1:0]      exact_hi,
  input  logic [16*NUM_EXACT-1:0]      exact_lo,
  input  logic [NUM_EXACT-1:0]         exact_en,
  input  logic                         hash_wr_en,
  input  logic [$clog2(HASH_REGS)-1:0] hash_wr_sel,
  input  logic [REG_W-1:0]             hash_wr_data,
  input  logic                         hash_clear,
  input  logic                         bc_reject,
  input  logic                         uc_promisc,
  input  logic                         mc_promisc,
  output logic                         done,
  output logic                         accept
);
  localparam int SEL_W  = $clog2(HASH_REGS);
  localparam int BIT_W  = $clog2(REG_W);
  localparam int IDX_W  = SEL_W + BIT_W;
  localparam int OCTETS = 6;

  logic [HASH_REGS-1:0][REG_W-1:0] table_q;
  logic [47:0] addr_q, shift_q;
  logic [31:0] crc_q;
  logic [2:0]  cnt_q;
  logic        busy_q, done_q, accept_q;

  function automatic logic [31:0] crc_octet(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r[0] ^ d[i]) ? ((r >> 1) ^ 32'hEDB8_8320) : (r >> 1);
    return r;
  endfunction

  logic [31:0]        fcs;
  logic [IDX_W-1:0]   idx;
  logic [NUM_EXACT-1:0] exact_eq;
  logic               last, is_bcast, is_group, bucket_hit, exact_hit, verdict;

  assign last       = busy_q && (cnt_q == 3'(OCTETS));
  assign fcs        = ~crc_q;
  assign idx        = fcs[31 -: IDX_W];
  assign bucket_hit = table_q[idx[IDX_W-1 -: SEL_W]][idx[BIT_W-1:0]];
  assign is_bcast   = &addr_q;
  assign is_group   = addr_q[40];
  assign exact_hit  = |exact_eq;

  for (genvar i = 0; i < NUM_EXACT; i++) begin : g_exact
    assign exact_eq[i] = exact_en[i] &&
                         ({exact_hi[32*i +: 32], exact_lo[16*i +: 16]} == addr_q);
  end

  assign verdict = is_bcast ? !bc_reject :
                   is_group ? (mc_promisc || exact_hit || bucket_hit) :
                              (uc_promisc || exact_hit || (addr_q == station_addr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      table_q <= '0;
    end else if (hash_clear) begin
      table_q <= '0;
    end else if (hash_wr_en) begin
      table_q[hash_wr_sel] <= hash_wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      addr_q   <= '0;
      shift_q  <= '0;
      crc_q    <= '1;
      cnt_q    <= '0;
      done_q   <= 1'b0;
      accept_q <= 1'b0;
    end else begin
      done_q   <= last;
      accept_q <= last && verdict;
      if (!busy_q) begin
        if (addr_valid) begin
          busy_q  <= 1'b1;
          addr_q  <= dst_addr;
          shift_q <= dst_addr;
          crc_q   <= '1;
          cnt_q   <= '0;
        end
      end else if (!last) begin
        crc_q   <= crc_octet(crc_q, shift_q[47:40]);
        shift_q <= shift_q << 8;
        cnt_q   <= cnt_q + 3'd1;
      end else begin
        busy_q <= 1'b0;
      end
    end
  end

  assign done   = done_q;
  assign accept = accept_q;

  a_r11_accept_only_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !accept);
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r2_strobe_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && addr_valid) |=> (busy_q && !done));
  a_r9_bcast_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (last && (&addr_q) && bc_reject) |=> (done && !accept));
  a_r10_uc_promisc: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !addr_q[40] && uc_promisc) |=> accept);
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    hash_clear |=> (table_q == '0));
endmodule

// File: tb/tb_eth_rx_addr_filter.sv
module tb_eth_rx_addr_filter;
  localparam int NE = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic addr_valid = 1'b0;
  logic [47:0] dst_addr = '0, station_addr = 48'h001B_2C3D_4E5F;
  logic [32*NE-1:0] exact_hi = '0;
  logic [16*NE-1:0] exact_lo = '0;
  logic [NE-1:0] exact_en = '0;
  logic hash_wr_en = 1'b0, hash_clear = 1'b0;
  logic [2:0] hash_wr_sel = '0;
  logic [31:0] hash_wr_data = '0;
  logic bc_reject = 1'b0, uc_promisc = 1'b0, mc_promisc = 1'b0;
  logic done, accept;

  int total = 0, fails = 0;
  bit [255:0] ht = '0;

  always #2 clk = ~clk;

  eth_rx_addr_filter #(.NUM_EXACT(NE), .HASH_REGS(8), .REG_W(32)) dut (
    .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .dst_addr(dst_addr),
    .station_addr(station_addr), .exact_hi(exact_hi), .exact_lo(exact_lo),
    .exact_en(exact_en), .hash_wr_en(hash_wr_en), .hash_wr_sel(hash_wr_sel),
    .hash_wr_data(hash_wr_data), .hash_clear(hash_clear), .bc_reject(bc_reject),
    .uc_promisc(uc_promisc), .mc_promisc(mc_promisc), .done(done), .accept(accept));

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit [7:0] bucket_of(input logic [47:0] a);
    logic [31:0] c;
    bit fb;
    c = '1;
    for (int o = 0; o < 6; o++)
      for (int j = 0; j < 8; j++) begin
        fb = c[0] ^ a[40 - 8*o + j];
        c = {1'b0, c[31:1]};
        if (fb) c = c ^ 32'hEDB8_8320;
      end
    c = ~c;
    return c[31:24];
  endfunction

  function automatic bit model(input logic [47:0] a);
    bit ex;
    ex = 1'b0;
    for (int i = 0; i < NE; i++)
      if (exact_en[i] && {exact_hi[32*i +: 32], exact_lo[16*i +: 16]} == a) ex = 1'b1;
    if (&a) return !bc_reject;
    if (a[40]) return mc_promisc || ex || ht[bucket_of(a)];
    return uc_promisc || ex || (a == station_addr);
  endfunction

  task automatic hash_write(input int r, input logic [31:0] d);
    @(negedge clk); hash_wr_en = 1'b1; hash_wr_sel = 3'(r); hash_wr_data = d;
    @(negedge clk); hash_wr_en = 1'b0;
    ht[r*32 +: 32] = d;
  endtask

  task automatic do_clear();
    @(negedge clk); hash_clear = 1'b1; hash_wr_en = 1'b1; hash_wr_sel = 3'd2; hash_wr_data = '1;
    @(negedge clk); hash_clear = 1'b0; hash_wr_en = 1'b0;
    ht = '0;
  endtask

  task automatic run_tx(input logic [47:0] a, input string req);
    bit exp, quiet;
    exp = model(a);
    quiet = 1'b1;
    @(negedge clk); dst_addr = a; addr_valid = 1'b1;
    @(negedge clk); addr_valid = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (done || accept) quiet = 1'b0;
    end
    check(quiet, "R2/R11 early output", 64'(quiet), 64'd1);
    @(negedge clk);
    check(done === 1'b1, "R2 done latency", 64'(done), 64'd1);
    check(accept === exp, req, 64'(accept), 64'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [47:0] a;
    logic [31:0] pat [8];
    bit seen;
    repeat (3) @(negedge clk);
    check(done === 1'b0 && accept === 1'b0, "R1 reset outputs", {62'd0, done, accept}, 64'd0);
    rst_n = 1'b1;

    // R1: buckets clear after reset, multicast rejected
    for (int k = 0; k < 8; k++)
      run_tx({8'h01, 8'h00, 8'h5E, 8'(k), 16'(k*977)}, "R1 cleared table rejects");

    // R4 / R3: station match and single-bit flips
    run_tx(station_addr, "R4 station match");
    for (int b = 0; b < 48; b++) run_tx(station_addr ^ (48'd1 << b), "R4/R3 station flip");

    // R5 exact entries
    exact_hi = {32'h02AA_BBCC, 32'h0100_5E7F, 32'h0211_2233};
    exact_lo = {16'hDDEE, 16'h0001, 16'h4455};
    exact_en = 3'b011;
    run_tx(48'h0211_2233_4455, "R5 unicast entry");
    run_tx(48'h0100_5E7F_0001, "R5 multicast entry");
    run_tx(48'h02AA_BBCC_DDEE, "R5 disabled entry");
    run_tx(48'h0211_2233_4454, "R5 near miss");

    // R6 / R7: bucket pattern and its inverse
    for (int r = 0; r < 8; r++) begin
      pat[r] = 32'hA5C3_0F96 ^ (32'(r) * 32'h1357_9BDF);
      hash_write(r, pat[r]);
    end
    for (int k = 0; k < 400; k++) begin
      a = {8'h03, 8'(k >> 3), 16'(k * 40503), 16'(k * 31 + 7)};
      run_tx(a, "R6 bucket hit pattern");
    end
    for (int r = 0; r < 8; r++) hash_write(r, ~pat[r]);
    for (int k = 0; k < 400; k++) begin
      a = {8'h03, 8'(k >> 3), 16'(k * 40503), 16'(k * 31 + 7)};
      run_tx(a, "R6 bucket inverse pattern");
    end

    // R6: unicast ignores a full table
    for (int r = 0; r < 8; r++) hash_write(r, '1);
    for (int k = 0; k < 8; k++) run_tx({8'h02, 8'h77, 32'(k * 12345)}, "R6 unicast not hashed");
    run_tx(48'h0155_6677_8899, "R6 full table accepts multicast");

    // R8: clear beats write, keeps station and entries
    do_clear();
    run_tx(48'h0155_6677_8899, "R8 cleared bucket");
    run_tx(station_addr, "R8 station kept");
    run_tx(48'h0100_5E7F_0001, "R8 entry kept");

    // R9 / R10
    run_tx('1, "R9 broadcast accepted");
    uc_promisc = 1'b1; mc_promisc = 1'b1;
    run_tx(48'h0299_8877_6655, "R10 unicast promisc");
    run_tx(48'h0199_8877_6655, "R10 multicast promisc");
    bc_reject = 1'b1;
    for (int r = 0; r < 8; r++) hash_write(r, '1);
    run_tx('1, "R9 broadcast rejected overrides");
    run_tx(48'h0199_8877_6655, "R10 multicast promisc with bc_reject");
    uc_promisc = 1'b0; mc_promisc = 1'b0; bc_reject = 1'b0;

    // R2: strobe held through busy period is ignored
    @(negedge clk); dst_addr = station_addr; addr_valid = 1'b1;
    repeat (7) @(negedge clk);
    check(done === 1'b0, "R2 no early done with held strobe", 64'(done), 64'd0);
    @(negedge clk); addr_valid = 1'b0;
    check(done === 1'b1 && accept === 1'b1, "R2 held strobe one decision", {62'd0, done, accept}, 64'd3);
    seen = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
    check(!seen, "R2 ignored strobe gives no pulse", 64'(seen), 64'd0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule